// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a clocked host and an external asynchronous static RAM with a 15-bit address and an 8-bit data word. The host offers one transfer at a time: a request pulse with an address, a direction flag and write data, taken only while the controller shows ready. The controller turns each transfer into a timed sequence on the memory's active-low chip enable, output enable and write enable pins. Completed reads come back as a one-cycle valid pulse with the captured byte.

Every interval on the memory side is a whole number of clock cycles. The count comes from nanosecond parameters by ceiling division, with a minimum of one cycle. Writes are ended by write enable, and output enable stays high for the whole write. The bidirectional data pins are split into an output value, a drive enable and an input value. After a read, the controller waits for the memory's output drivers to turn off before it drives write data.

Top module: `sram_bus_ctrl`

## Requirements
- R1: While the synchronous active-high reset is applied, and in the cycle after it is removed, host_ready is 1. mem_ce_n, mem_oe_n and mem_we_n are 1, and mem_dq_t and host_rvalid are 0.
- R2: host_ready is 1 only while the controller is idle. At that time mem_ce_n is 1 and the data pins are not driven. A request seen with host_ready at 1 latches address, data and direction, and host_ready is 0 in the next cycle.
- R3: A read holds mem_ce_n=0, mem_oe_n=0 and mem_we_n=1 for RD_CYC = max(ceil(T_AA/P), ceil(T_DOE/P)) cycles, where P is the clock period. That is 11 cycles with the defaults. The byte on mem_dq_i is captured on the last of those cycles. In the next cycle host_rvalid is 1 for exactly one cycle with the byte on host_rdata, while mem_ce_n and mem_oe_n are 1.
- R4: A write holds mem_ce_n=0 and mem_oe_n=1 throughout. It has one cycle with data driven and mem_we_n=1, then mem_we_n=0 for WE_CYC cycles. Then mem_we_n and mem_ce_n return to 1 and mem_dq_t drops to 0, all in the same cycle.
- R5: WE_CYC = max(ceil(T_PWE/P), ceil(T_SD/P), ceil(T_AW/P)-1, ceil(T_WC/P)-2, 1). As a result, the write-enable low time is at least T_PWE (40 ns). Data is driven at least T_SD (25 ns) before write enable rises. The address is stable at least T_AW (45 ns) before that edge.
- R6: mem_dq_t is 1 only while mem_ce_n is 0 and mem_oe_n is 1.
- R7: After mem_oe_n rises at the end of a read, mem_dq_t does not rise until at least T_HZ (20 ns) later. The controller waits HZ_CYC = ceil(T_HZ/P) extra cycles before the first write that follows a read.
- R8: Strobe pairs are legal at all times. mem_we_n=0 implies mem_ce_n=0 and mem_oe_n=1. mem_oe_n=0 implies mem_ce_n=0 and mem_we_n=1.
- R9: The memory sees the latched host address and write data. A read after a write to the same address returns the written byte.
- R10: Reset applied in the middle of a read returns the controller to idle, with all strobes at 1 and no data drive, in the cycle after the reset edge. No host_rvalid pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Transfer request, taken while host_ready is 1 |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Transfer address |
| host_wdata | input | DATA_W | Write byte |
| host_ready | output | 1 | Controller idle and able to take a request |
| host_rdata | output | DATA_W | Captured read byte |
| host_rvalid | output | 1 | One-cycle pulse: host_rdata holds a read result |
| mem_addr | output | ADDR_W | Memory address pins |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_o | output | DATA_W | Value for the data pins when driven |
| mem_dq_t | output | 1 | 1 = controller drives the data pins |
| mem_dq_i | input | DATA_W | Value sensed on the data pins |

## Verification
Two events can coincide here. One is the end of a read, when output enable is released and the memory's drivers are still turning off. The other is a write accepted as soon as ready returns, which wants to drive the same pins. The bench provokes this by issuing a write to the address just read the moment ready reappears. A behavioural memory model records when output enable rose and when the drive enable rose, and judges the gap against the 20 ns turn-off window. The model also hands out a wrong byte until 54 ns into each read and times every write-enable pulse, so an access shortened by one cycle shows up as a data or timing mismatch.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACC,
    ST_RD_DONE,
    ST_WR_TURN,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_END
  } ctrl_state_t;

  // nanoseconds to clock cycles, rounded up, never below one cycle
  function automatic int ns_to_cyc(input int ns, input int period_ns);
    int c;
    c = (ns + period_ns - 1) / period_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
module sram_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  // loaded with length-1 on phase entry, so a phase lasts length cycles
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_req_latch.sv
`timescale 1ns/1ps
module sram_req_latch #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_wr,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data,
  output logic              out_wr
);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_addr <= '0;
      out_data <= '0;
      out_wr   <= 1'b0;
    end else if (take) begin
      out_addr <= in_addr;
      out_data <= in_data;
      out_wr   <= in_wr;
    end
  end

endmodule

// File: rtl/sram_rd_capture.sv
`timescale 1ns/1ps
module sram_rd_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= capture;
      if (capture) rdata <= dq_in;
    end
  end

  AST_RVALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rvalid |=> !rvalid); // R3

endmodule

// File: rtl/sram_bus_ctrl.sv
`timescale 1ns/1ps
module sram_bus_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 15,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 5,
  parameter int T_PWE         = 40,
  parameter int T_SD          = 25,
  parameter int T_AW          = 45,
  parameter int T_WC          = 55,
  parameter int T_AA          = 55,
  parameter int T_DOE         = 25,
  parameter int T_HZ          = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_req,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_ready,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_rvalid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_t,
  input  logic [DATA_W-1:0] mem_dq_i
);

  localparam int RD_CYC  = imax(ns_to_cyc(T_AA, CLK_PERIOD_NS), ns_to_cyc(T_DOE, CLK_PERIOD_NS));
  localparam int HZ_CYC  = ns_to_cyc(T_HZ, CLK_PERIOD_NS);
  localparam int WE_CYC  = imax(imax(ns_to_cyc(T_PWE, CLK_PERIOD_NS), ns_to_cyc(T_SD, CLK_PERIOD_NS)),
                                imax(ns_to_cyc(T_AW, CLK_PERIOD_NS) - 1,
                                     imax(ns_to_cyc(T_WC, CLK_PERIOD_NS) - 2, 1)));
  localparam int MAX_CYC = imax(RD_CYC, imax(HZ_CYC, WE_CYC));
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  ctrl_state_t      state_q, nxt;
  logic             take;
  logic             t_load;
  logic [CNT_W-1:0] t_val;
  logic             t_expired;
  logic             turn_pend_q;
  logic             op_wr_q;
  logic             rd_cap;

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (t_load),
    .load_val (t_val),
    .expired  (t_expired)
  );

  sram_req_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_latch (
    .clk      (clk),
    .rst      (rst),
    .take     (take),
    .in_addr  (host_addr),
    .in_data  (host_wdata),
    .in_wr    (host_wr),
    .out_addr (mem_addr),
    .out_data (mem_dq_o),
    .out_wr   (op_wr_q)
  );

  assign rd_cap = (state_q == ST_RD_ACC) && t_expired;

  sram_rd_capture #(.DATA_W(DATA_W)) u_rdcap (
    .clk     (clk),
    .rst     (rst),
    .capture (rd_cap),
    .dq_in   (mem_dq_i),
    .rdata   (host_rdata),
    .rvalid  (host_rvalid)
  );

  // next state
  always_comb begin
    nxt  = state_q;
    take = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (host_req) begin
          take = 1'b1;
          if (!host_wr)        nxt = ST_RD_ACC;
          else if (turn_pend_q) nxt = ST_WR_TURN;
          else                 nxt = ST_WR_SETUP;
        end
      end
      ST_RD_ACC:   if (t_expired) nxt = ST_RD_DONE;
      ST_RD_DONE:  nxt = ST_IDLE;
      ST_WR_TURN:  if (t_expired) nxt = ST_WR_SETUP;
      ST_WR_SETUP: nxt = ST_WR_PULSE;
      ST_WR_PULSE: if (t_expired) nxt = ST_WR_END;
      ST_WR_END:   nxt = ST_IDLE;
      default:     nxt = ST_IDLE;
    endcase
  end

  // phase length loaded on entry into a counted phase
  always_comb begin
    t_load = 1'b0;
    t_val  = '0;
    if (nxt != state_q) begin
      case (nxt)
        ST_RD_ACC:   begin t_load = 1'b1; t_val = CNT_W'(RD_CYC - 1); end
        ST_WR_TURN:  begin t_load = 1'b1; t_val = CNT_W'(HZ_CYC - 1); end
        ST_WR_PULSE: begin t_load = 1'b1; t_val = CNT_W'(WE_CYC - 1); end
        default:     begin t_load = 1'b0; t_val = '0; end
      endcase
    end
  end

  // state and glitch-free registered pin decode
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      turn_pend_q <= 1'b0;
      host_ready  <= 1'b1;
      mem_ce_n    <= 1'b1;
      mem_oe_n    <= 1'b1;
      mem_we_n    <= 1'b1;
      mem_dq_t    <= 1'b0;
    end else begin
      state_q    <= nxt;
      host_ready <= (nxt == ST_IDLE);
      mem_ce_n   <= !((nxt == ST_RD_ACC) || (nxt == ST_WR_SETUP) || (nxt == ST_WR_PULSE));
      mem_oe_n   <= !(nxt == ST_RD_ACC);
      mem_we_n   <= !(nxt == ST_WR_PULSE);
      mem_dq_t   <= (nxt == ST_WR_SETUP) || (nxt == ST_WR_PULSE);
      if (nxt == ST_RD_ACC)
        turn_pend_q <= 1'b1;
      else if ((state_q == ST_WR_TURN) && t_expired)
        turn_pend_q <= 1'b0;
    end
  end

  AST_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (host_ready && mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_t && !host_rvalid)); // R1

  AST_READY_IDLE_PINS: assert property (@(posedge clk) disable iff (rst)
    host_ready |-> (mem_ce_n && !mem_dq_t)); // R2

  AST_RELEASE_WITH_WE: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (!mem_dq_t && mem_ce_n)); // R4

  AST_ADDR_HELD_WRITE: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |=> $stable(mem_addr)); // R5

  AST_DRIVE_ONLY_WRITE: assert property (@(posedge clk) disable iff (rst)
    mem_dq_t |-> (mem_oe_n && !mem_ce_n)); // R6

  AST_WE_NEEDS_CE: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n)); // R8

  AST_OE_NEEDS_CE: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> (!mem_ce_n && mem_we_n)); // R8

  AST_DIR_WRITE: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> op_wr_q); // R9

  AST_DIR_READ: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> !op_wr_q); // R9

endmodule

// File: tb/sram_bus_ctrl_tb.sv
`timescale 1ns/1ps
module sram_bus_ctrl_tb;

  localparam int  AW = 15;
  localparam int  DW = 8;
  localparam int  P  = 5;
  localparam real T_PWE_R = 40.0;
  localparam real T_SD_R  = 25.0;
  localparam real T_AW_R  = 45.0;
  localparam real T_HZ_R  = 20.0;
  localparam int  T_AA    = 55;
  localparam int  RD_CYC_EXP = 11;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          host_req = 1'b0;
  logic          host_wr = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0;
  logic          host_ready, host_rvalid;
  logic [DW-1:0] host_rdata;
  logic [AW-1:0] mem_addr;
  logic          mem_ce_n, mem_oe_n, mem_we_n, mem_dq_t;
  logic [DW-1:0] mem_dq_o, mem_dq_i;

  always #2.5 clk = ~clk;

  sram_bus_ctrl u_dut (
    .clk(clk), .rst(rst),
    .host_req(host_req), .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_ready(host_ready), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_o(mem_dq_o), .mem_dq_t(mem_dq_t), .mem_dq_i(mem_dq_i)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int ps(input real d);
    return int'(d * 1000.0);
  endfunction

  // ---------------- memory model ----------------
  logic [DW-1:0] sram  [logic [AW-1:0]];
  logic [DW-1:0] shadow[logic [AW-1:0]];
  logic [DW-1:0] rd_word = '0;
  bit            rd_ok = 0;
  bit            we_armed = 0;
  real           t_oe_rise = -1000.0, t_we_fall = 0.0, t_addr = 0.0, t_dq = 0.0;
  logic [AW-1:0] exp_waddr = '0;
  logic [DW-1:0] exp_wdata = '0;
  int            wr_seen = 0, wr_issued = 0;

  function automatic logic [DW-1:0] peek(input logic [AW-1:0] a);
    return sram.exists(a) ? sram[a] : 8'h00;
  endfunction
  function automatic logic [DW-1:0] ref_peek(input logic [AW-1:0] a);
    return shadow.exists(a) ? shadow[a] : 8'h00;
  endfunction

  // wrong byte on the pins until 54 ns into the read
  assign mem_dq_i = (!mem_ce_n && !mem_oe_n && mem_we_n && rd_ok) ? rd_word : (rd_word ^ 8'h5A);

  always @(negedge mem_oe_n) begin
    rd_ok = 0;
    #1;
    rd_word = peek(mem_addr);
    #(T_AA - 2);
    rd_ok = 1;
  end
  always @(posedge mem_oe_n) begin
    rd_ok = 0;
    t_oe_rise = $realtime;
  end
  always @(mem_addr) t_addr = $realtime;
  always @(mem_dq_o) t_dq = $realtime;

  always @(posedge mem_dq_t) begin
    t_dq = $realtime;
    check(($realtime - t_oe_rise) >= T_HZ_R, "R7", "drive after OE rise ps", ps($realtime - t_oe_rise), ps(T_HZ_R));
    #1;
    check(mem_oe_n && !mem_ce_n, "R6", "drive with oe_n/ce_n", {mem_oe_n, mem_ce_n}, 2);
  end

  always @(negedge mem_we_n) begin
    t_we_fall = $realtime;
    we_armed = 1;
    #1;
    check(!mem_ce_n && mem_oe_n, "R8", "we low strobes ce_n/oe_n", {mem_ce_n, mem_oe_n}, 1);
    check(mem_dq_t, "R4", "data driven during we low", mem_dq_t, 1);
  end

  always @(posedge mem_we_n) begin
    if (we_armed) begin
      we_armed = 0;
      wr_seen++;
      check(($realtime - t_we_fall) >= T_PWE_R, "R5", "we pulse ps", ps($realtime - t_we_fall), ps(T_PWE_R));
      check(($realtime - t_dq) >= T_SD_R, "R5", "data setup ps", ps($realtime - t_dq), ps(T_SD_R));
      check(($realtime - t_addr) >= T_AW_R, "R5", "address setup ps", ps($realtime - t_addr), ps(T_AW_R));
      check(mem_addr == exp_waddr, "R9", "write address", mem_addr, exp_waddr);
      check(mem_dq_o == exp_wdata, "R9", "write data", mem_dq_o, exp_wdata);
      sram[mem_addr] = mem_dq_o;
      #1;
      check(!mem_dq_t && mem_ce_n, "R4", "release with we rise dq_t/ce_n", {mem_dq_t, mem_ce_n}, 1);
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct { logic [DW-1:0] data; real t_acc; } exp_t;
  exp_t exp_q[$];
  bit   prev_rvalid = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (host_rvalid) begin
        check(!prev_rvalid, "R3", "rvalid longer than one cycle", 1, 0);
        check(mem_ce_n && mem_oe_n, "R3", "strobes at rvalid ce_n/oe_n", {mem_ce_n, mem_oe_n}, 3);
        if (exp_q.size() == 0) begin
          check(0, "R10", "unexpected rvalid", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(host_rdata == e.data, "R9", "read data", host_rdata, e.data);
          check(ps($realtime - e.t_acc) == ps(real'(RD_CYC_EXP * P)), "R3", "read latency ps",
                ps($realtime - e.t_acc), ps(real'(RD_CYC_EXP * P)));
        end
      end
      prev_rvalid = host_rvalid;
    end else begin
      prev_rvalid = 0;
    end
  end

  // ---------------- driver ----------------
  task automatic host_op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    exp_t e;
    @(negedge clk);
    while (!host_ready) @(negedge clk);
    host_req = 1'b1; host_wr = wr; host_addr = a; host_wdata = d;
    if (wr) begin
      exp_waddr = a; exp_wdata = d; shadow[a] = d; wr_issued++;
    end
    @(negedge clk);
    host_req = 1'b0;
    check(!host_ready, "R2", "ready after accept", host_ready, 0);
    if (!wr) begin
      e.data = ref_peek(a);
      e.t_acc = $realtime;
      exp_q.push_back(e);
    end
  endtask

  task automatic wait_quiet();
    for (int i = 0; i < 200 && (exp_q.size() != 0 || !host_ready); i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(200000 * P);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: pins right after reset
    check(host_ready && mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_t && !host_rvalid,
          "R1", "reset state", {host_ready, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_t, host_rvalid}, 6'b111100);

    // R9: boundary addresses and data patterns
    host_op(1, 15'h0000, 8'h00);
    host_op(1, 15'h7FFF, 8'hFF);
    host_op(1, 15'h1234, 8'hA5);
    host_op(1, 15'h1235, 8'h5A);
    host_op(0, 15'h0000, 8'h00);
    host_op(0, 15'h7FFF, 8'h00);
    host_op(0, 15'h1234, 8'h00);
    host_op(0, 15'h1235, 8'h00);
    host_op(0, 15'h0100, 8'h00);
    wait_quiet();
    check(host_ready, "R2", "idle ready", host_ready, 1);

    // R7: write issued the moment a read completes
    host_op(0, 15'h1234, 8'h00);
    host_op(1, 15'h1234, 8'h3C);
    host_op(0, 15'h1234, 8'h00);
    host_op(1, 15'h2000, 8'h81);
    host_op(1, 15'h2001, 8'h7E);
    host_op(0, 15'h2001, 8'h00);
    host_op(0, 15'h2000, 8'h00);
    wait_quiet();

    // R10: reset in the middle of a read
    host_op(0, 15'h7FFF, 8'h00);
    repeat (3) @(negedge clk);
    rst = 1'b1;
    exp_q.delete();
    @(negedge clk);
    rst = 1'b0;
    check(host_ready && mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_t,
          "R10", "pins after mid-read reset", {host_ready, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_t}, 5'b11110);
    repeat (20) @(negedge clk);
    host_op(0, 15'h7FFF, 8'h00);
    host_op(1, 15'h0001, 8'hC3);
    host_op(0, 15'h0001, 8'h00);
    wait_quiet();

    check(exp_q.size() == 0, "R3", "reads outstanding", exp_q.size(), 0);
    check(wr_seen == wr_issued, "R4", "write pulses seen", wr_seen, wr_issued);
    finish_run();
  end

endmodule